// File: doc/BRIEF.md
# Display RAM Host Address Generator

This block produces the host-side address for a graphic display memory of 132 columns by 65 rows. The rows are grouped into nine pages: eight full pages of eight rows each, where one byte carries eight vertically stacked pixels, and a final page holding a single row. A host drives bytes through one port together with a data/command select. Command bytes set the page, set the column in two nibble steps, or pick the column direction. Data bytes are reads or writes at the current address, and each one moves the column forward by one so that a row of bytes can be streamed without addressing each byte again.

The column counter stops at the first value past the last valid column and stays there until the host sets a column again. It never carries into the page. A direction select mirrors logical columns onto physical columns so that a panel mounted either way round can be served. The block emits the page, the physical column, a write strobe with the byte to store, and a read strobe with the byte returned to the host. The memory array itself sits outside the block.

Top module: `disp_addr_gen`

## Requirements
- R1: After reset, page is 0, physCol is 0, the direction is normal, and wrEn and rdEn are low.
- R2: A command byte 0xB0 to 0xB8 loads its low nibble into the page on the next clock; 0xB9 to 0xBF leave the page unchanged.
- R3: A command byte 0x1h loads h into the upper four column bits, and a command byte 0x0h loads h into the lower four column bits; the other nibble is kept.
- R4: A data access (isData high, isRead low for a write or high for a read) at a column of 0 to 131 uses the current column in that cycle, and the column is one higher on the next clock.
- R5: When the column is 132 or above, data accesses leave it unchanged, wrEn and rdEn stay low, and physCol equals the column; a later column command sets it again and streaming resumes.
- R6: Data accesses never change the page, including the step from column 131 to 132.
- R7: Command 0xA1 selects reversed direction, in which physCol is 131 minus the column for columns 0 to 131; 0xA0 restores normal direction, in which physCol equals the column.
- R8: While the page is 8, wrData carries only bit 0 of the host byte with bits 7 to 1 zero, and hostRdData carries only bit 0 of the memory byte with bits 7 to 1 zero; on pages 0 to 7 both pass all eight bits.
- R9: wrEn is high only for a valid data write in range and rdEn only for a valid data read in range; command bytes, other unassigned command bytes such as 0x40, and cycles with valid low raise neither and change no address state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Host byte present this cycle |
| isData | input | 1 | 1 = display data, 0 = command |
| isRead | input | 1 | For data: 1 = read, 0 = write |
| hostByte | input | 8 | Command or write data from the host |
| memRdData | input | 8 | Byte read from the display memory at the current address |
| page | output | 4 | Current page index |
| physCol | output | 8 | Physical column after direction mapping |
| wrEn | output | 1 | Write strobe to the display memory |
| wrData | output | 8 | Byte to store, masked on the single-row page |
| rdEn | output | 1 | Read strobe to the display memory |
| hostRdData | output | 8 | Byte returned to the host, masked on the single-row page |

## Verification
The bench builds the block with its default parameters: 132 columns, nine pages and an eight-bit column counter. With those values the lock point at column 132 is reached in two writes after presetting the column to 130, so the freeze, the suppressed strobes and the release by a fresh column command are all driven directly, along with the mirror mapping at both ends of the column range and the single-row masking on page 8.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;
  typedef struct packed {
    logic       ldPage;
    logic       ldColHi;
    logic       ldColLo;
    logic       ldDir;
    logic       wrAcc;
    logic       rdAcc;
    logic [3:0] nib;
    logic       dirRev;
  } ctrlStb_t;
endpackage

// File: rtl/disp_addr_ctrl.sv
module disp_addr_ctrl
  import disp_addr_pkg::*;
#(
  parameter int NumPages = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       valid,
  input  logic       isData,
  input  logic       isRead,
  input  logic [7:0] hostByte,
  output ctrlStb_t   stb
);
  localparam logic [3:0] PageOp = 4'hB;
  localparam logic [3:0] ColHiOp = 4'h1;
  localparam logic [3:0] ColLoOp = 4'h0;
  localparam logic [6:0] DirOp = 7'b1010000;

  logic isCmd;
  assign isCmd = valid && !isData;

  always_comb begin
    stb         = '0;
    stb.nib     = hostByte[3:0];
    stb.dirRev  = hostByte[0];
    stb.wrAcc   = valid && isData && !isRead;
    stb.rdAcc   = valid && isData && isRead;
    stb.ldPage  = isCmd && (hostByte[7:4] == PageOp) && (int'(hostByte[3:0]) < NumPages);
    stb.ldColHi = isCmd && (hostByte[7:4] == ColHiOp);
    stb.ldColLo = isCmd && (hostByte[7:4] == ColLoOp);
    stb.ldDir   = isCmd && (hostByte[7:1] == DirOp);
  end

  // R9: at most one action per host byte
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ldPage, stb.ldColHi, stb.ldColLo, stb.ldDir, stb.wrAcc, stb.rdAcc}));
endmodule

// File: rtl/disp_addr_path.sv
module disp_addr_path
  import disp_addr_pkg::*;
#(
  parameter int NumCols  = 132,
  parameter int NumPages = 9,
  parameter int ColW     = 8,
  parameter int PageW    = 4,
  parameter int DataW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         stb,
  input  logic [DataW-1:0] hostByte,
  input  logic [DataW-1:0] memRdData,
  output logic [PageW-1:0] page,
  output logic [ColW-1:0]  physCol,
  output logic             wrEn,
  output logic [DataW-1:0] wrData,
  output logic             rdEn,
  output logic [DataW-1:0] hostRdData
);
  localparam int HiW = ColW - 4;
  localparam logic [ColW-1:0]  LastCol  = ColW'(NumCols - 1);
  localparam logic [PageW-1:0] LastPage = PageW'(NumPages - 1);

  logic [PageW-1:0] pageQ;
  logic [ColW-1:0]  colQ;
  logic             revQ;
  logic             inRange;
  logic             onLastPage;

  assign inRange    = (colQ <= LastCol);
  assign onLastPage = (pageQ == LastPage);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageQ <= '0;
      colQ  <= '0;
      revQ  <= 1'b0;
    end else begin
      if (stb.ldPage)  pageQ <= stb.nib[PageW-1:0];
      if (stb.ldDir)   revQ  <= stb.dirRev;
      if (stb.ldColHi) colQ  <= {stb.nib[HiW-1:0], colQ[3:0]};
      else if (stb.ldColLo) colQ <= {colQ[ColW-1:4], stb.nib};
      else if ((stb.wrAcc || stb.rdAcc) && inRange) colQ <= colQ + 1'b1;
    end
  end

  always_comb begin
    page       = pageQ;
    physCol    = (revQ && inRange) ? (LastCol - colQ) : colQ;
    wrEn       = stb.wrAcc && inRange;
    rdEn       = stb.rdAcc && inRange;
    wrData     = onLastPage ? DataW'(hostByte[0]) : hostByte;
    hostRdData = onLastPage ? DataW'(memRdData[0]) : memRdData;
  end

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((stb.wrAcc || stb.rdAcc) && inRange) |=> (colQ == ColW'($past(colQ) + 1'b1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!inRange && !stb.ldColHi && !stb.ldColLo) |=> $stable(colQ));

  p_page_kept_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrAcc || stb.rdAcc) |=> $stable(pageQ));

  p_page_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    pageQ <= LastPage);

  p_strobe_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn || rdEn) |-> (physCol <= LastCol));
endmodule

// File: rtl/disp_addr_gen.sv
module disp_addr_gen
  import disp_addr_pkg::*;
#(
  parameter int NumCols  = 132,
  parameter int NumPages = 9,
  parameter int ColW     = 8,
  parameter int PageW    = 4,
  parameter int DataW    = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             valid,
  input  logic             isData,
  input  logic             isRead,
  input  logic [DataW-1:0] hostByte,
  input  logic [DataW-1:0] memRdData,
  output logic [PageW-1:0] page,
  output logic [ColW-1:0]  physCol,
  output logic             wrEn,
  output logic [DataW-1:0] wrData,
  output logic             rdEn,
  output logic [DataW-1:0] hostRdData
);
  ctrlStb_t stb;

  disp_addr_ctrl #(.NumPages(NumPages)) u_ctrl (
    .clk(clk), .rstN(rstN), .valid(valid), .isData(isData),
    .isRead(isRead), .hostByte(hostByte[7:0]), .stb(stb)
  );

  disp_addr_path #(
    .NumCols(NumCols), .NumPages(NumPages), .ColW(ColW),
    .PageW(PageW), .DataW(DataW)
  ) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .hostByte(hostByte),
    .memRdData(memRdData), .page(page), .physCol(physCol),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .hostRdData(hostRdData)
  );

  p_cmd_no_strobe_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!valid || !isData) |-> (!wrEn && !rdEn));
endmodule

// File: tb/disp_addr_gen_bench.sv
module disp_addr_gen_bench;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic valid = 1'b0, isData = 1'b0, isRead = 1'b0;
  logic [7:0] hostByte = '0, memRdData = '0;
  logic [3:0] page;
  logic [7:0] physCol, wrData, hostRdData;
  logic wrEn, rdEn;

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int mPage = 0, mCol = 0;
  bit mRev = 0;

  always #(ClkPeriod/2) clk = ~clk;

  disp_addr_gen u_disp_addr_gen (
    .clk(clk), .rstN(rstN), .valid(valid), .isData(isData), .isRead(isRead),
    .hostByte(hostByte), .memRdData(memRdData), .page(page), .physCol(physCol),
    .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn), .hostRdData(hostRdData)
  );

  task automatic check(string tag);
    int ePhys, eWr, eRd, eWd, eRdData;
    bit inR;
    inR     = (mCol <= 131);
    ePhys   = (mRev && inR) ? 131 - mCol : mCol;
    eWr     = (valid && isData && !isRead && inR);
    eRd     = (valid && isData && isRead && inR);
    eWd     = (mPage == 8) ? (hostByte & 1) : hostByte;
    eRdData = (mPage == 8) ? (memRdData & 1) : memRdData;
    compared++;
    if (page != mPage || physCol != ePhys || wrEn != eWr || rdEn != eRd ||
        wrData != eWd || hostRdData != eRdData) begin
      mismatched++;
      $display("FAIL %s: page=%0d physCol=%0d wrEn=%0b rdEn=%0b wrData=%h rdData=%h expected page=%0d physCol=%0d wrEn=%0b rdEn=%0b wrData=%h rdData=%h",
               tag, page, physCol, wrEn, rdEn, wrData, hostRdData,
               mPage, ePhys, eWr, eRd, eWd[7:0], eRdData[7:0]);
    end
  endtask

  task automatic modelStep();
    int d;
    d = hostByte;
    if (!valid) return;
    if (isData) begin
      if (mCol <= 131) mCol++;
    end else begin
      if (d >= 'hB0 && d <= 'hB8) mPage = d & 15;
      if ((d >> 4) == 1) mCol = (mCol & 15) | ((d & 15) << 4);
      if ((d >> 4) == 0) mCol = (mCol & 'hF0) | (d & 15);
      if (d == 'hA0) mRev = 0;
      if (d == 'hA1) mRev = 1;
    end
  endtask

  task automatic op(bit v, bit dat, bit rd, logic [7:0] b, logic [7:0] m, string tag);
    @(negedge clk);
    valid = v; isData = dat; isRead = rd; hostByte = b; memRdData = m;
    #1 check(tag);
    @(posedge clk);
    modelStep();
  endtask

  task automatic cmd(logic [7:0] b, string tag);
    op(1, 0, 0, b, 8'h00, tag);
  endtask

  task automatic setCol(int c, string tag);
    cmd(8'h10 | 8'(c >> 4), tag);
    cmd(8'(c & 15), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R1");
    rstN = 1'b1;
    op(0, 0, 0, 8'h00, 8'h00, "R1");
    // streaming writes from column 0
    for (int i = 0; i < 4; i++) op(1, 1, 0, 8'(8'h5A + i), 8'h00, "R4");
    op(1, 1, 1, 8'h00, 8'hC3, "R4");
    // page commands, valid and out of range
    cmd(8'hB3, "R2");
    cmd(8'hB9, "R2");
    cmd(8'hBF, "R2");
    op(1, 1, 0, 8'hFF, 8'h00, "R2");
    // nibble loads keep the other nibble
    cmd(8'h17, "R3");
    cmd(8'h05, "R3");
    cmd(8'h12, "R3");
    cmd(8'h0A, "R3");
    op(1, 1, 0, 8'h81, 8'h00, "R3");
    // unassigned command and idle data
    cmd(8'h40, "R9");
    op(0, 1, 0, 8'h77, 8'h00, "R9");
    op(0, 1, 1, 8'h77, 8'h00, "R9");
    // run to the end of the row and lock
    setCol(130, "R5");
    for (int i = 0; i < 5; i++) op(1, 1, i[0], 8'hA5, 8'h3C, "R5");
    op(1, 1, 0, 8'h11, 8'h00, "R6");
    setCol(3, "R5");
    op(1, 1, 0, 8'h22, 8'h00, "R5");
    // reverse direction at both ends
    cmd(8'hA1, "R7");
    setCol(0, "R7");
    op(1, 1, 0, 8'h01, 8'h00, "R7");
    setCol(131, "R7");
    op(1, 1, 0, 8'h02, 8'h00, "R7");
    op(1, 1, 0, 8'h03, 8'h00, "R7");
    cmd(8'hA0, "R7");
    setCol(40, "R7");
    op(1, 1, 0, 8'h04, 8'h00, "R7");
    // single-row page masking
    cmd(8'hB8, "R8");
    op(1, 1, 0, 8'hFE, 8'h00, "R8");
    op(1, 1, 0, 8'hFF, 8'h00, "R8");
    op(1, 1, 1, 8'h00, 8'hFF, "R8");
    op(1, 1, 1, 8'h00, 8'hAA, "R8");
    cmd(8'hB7, "R8");
    op(1, 1, 0, 8'hFE, 8'h00, "R8");
    op(1, 1, 1, 8'h00, 8'hAA, "R8");
    // reset again mid-stream
    @(negedge clk);
    rstN = 1'b0; valid = 0;
    @(posedge clk);
    mPage = 0; mCol = 0; mRev = 0;
    @(negedge clk);
    #1 check("R1");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(ClkPeriod * 20000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule